// File: doc/BRIEF.md
# Fetch line splitter with stream-tagged discard

This pipeline stage sits between a line fetcher and an instruction decoder. The fetcher pushes fixed-size lines into a small internal buffer. Each line carries a stream number, a prediction number and the address of its first instruction. The stage cuts each line into fixed-width instructions and offers up to `OUT_W` of them per cycle to decode over a valid/ready handshake. Every instruction carries its own PC and a fetch sequence number. When a line is exhausted and lanes are still free, the next buffered line can continue in the same cycle, under the control of a parameter.

Two events change control flow. The first is a "predicted taken" strobe with a target, which stands in for a branch predictor. It bumps the local prediction number, remembers the stream that was current at that moment, flushes the buffer, and forwards the target to the fetcher. The second is a redirect from execute, which flushes the buffer and takes on a new stream number. After a prediction, lines that are still in flight are discarded only if two things hold: their prediction number disagrees with the local one, and they belong to the remembered stream. A line from a newer stream is kept even though it carries an old prediction number.

Top module: `fetch_splitter`

## Requirements
- R1: After reset, `out_valid` is 0, `drained` is 1, `cur_pred` is 0 and `line_ready` is 1.
- R2: Each kept line yields `LINE_INSNS` instructions in order, instruction i being `line_data[i*INSN_W +: INSN_W]`. At most `OUT_W` are offered per cycle. The valid lanes in `out_lanes` always run contiguously from lane 0.
- R3: With `MULTI_LINE` set, the next buffered line fills the remaining lanes in the same cycle once the head line runs out.
- R4: Instructions transfer only in a cycle with `out_valid` and `out_ready` both high. While `out_ready` is low, lane 0 keeps its instruction, PC and sequence number, and `out_valid` stays high. A line leaves the buffer only after its last instruction has transferred.
- R5: A line's PC is loaded from `line_pc` when its stream number differs from that of the last line seen, or when no PC is held. Otherwise `line_pc` is ignored, and each instruction's PC is the previous one plus `INSN_W/8`.
- R6: Fetch sequence numbers start at 0 after reset and rise by one for each transferred instruction, in lane order.
- R7: A buffered line is dropped without output when its prediction number differs from `cur_pred` and its stream number equals the stream remembered at the last prediction. Dropping a line clears the held PC.
- R8: A `pred_taken` strobe raises `cur_pred` by one in the next cycle and flushes the buffer. It also clears the held PC and drives `fetch_redir_valid`=1 with `fetch_redir_pc`=`pred_target` in the same cycle.
- R9: `ex_redirect` flushes the buffer, clears the held PC and forces `out_valid` low in that cycle. It wins over a `pred_taken` in the same cycle: `cur_pred` is unchanged and `fetch_redir_valid` stays 0.
- R10: A line offered in a flush cycle is dropped. `line_ready` is 0 while the buffer holds `DEPTH` lines.
- R11: `drained` is 1 only when the buffer is empty and no line is partly emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_valid | input | 1 | Fetcher offers a line |
| line_ready | output | 1 | Buffer has room |
| line_data | input | LINE_INSNS*INSN_W | Line contents, instruction 0 in the low bits |
| line_stream | input | SEQ_W | Stream number of the line |
| line_pred | input | SEQ_W | Prediction number of the line |
| line_pc | input | ADDR_W | Address of the line's first instruction |
| out_valid | output | 1 | At least one lane offered |
| out_ready | input | 1 | Decode accepts the offered lanes |
| out_lanes | output | OUT_W | Per-lane valid |
| out_insn | output | OUT_W*INSN_W | Instructions per lane |
| out_pc | output | OUT_W*ADDR_W | PC per lane |
| out_fseq | output | OUT_W*FSEQ_W | Fetch sequence number per lane |
| pred_taken | input | 1 | Predicted control-flow change strobe |
| pred_target | input | ADDR_W | Predicted target |
| fetch_redir_valid | output | 1 | Prediction forwarded to fetcher |
| fetch_redir_pc | output | ADDR_W | Forwarded target |
| cur_pred | output | SEQ_W | Local prediction number |
| ex_redirect | input | 1 | Redirect from execute |
| ex_stream | input | SEQ_W | New stream number on redirect |
| drained | output | 1 | Nothing buffered or partly emitted |

## Verification
The prediction strobe and the execute redirect can arrive in the same cycle. The bench raises both together with lines already buffered. It then checks that the fetcher sees no forwarded prediction, that `cur_pred` keeps its value, and that the buffer is emptied. A second overlap puts a line offer in the same cycle as a prediction. The bench judges that case by `drained` staying high afterwards with no instruction appearing. Random stalls of `out_ready` against random line arrivals exercise the overlap of emission and buffer filling, including lines that span two cycles.

// File: rtl/fetch_splitter.sv
module fetch_splitter #(
  parameter int LINE_INSNS = 4,
  parameter int INSN_W     = 32,
  parameter int OUT_W      = 3,
  parameter int DEPTH      = 4,
  parameter int SEQ_W      = 4,
  parameter int ADDR_W     = 16,
  parameter int FSEQ_W     = 12,
  parameter bit MULTI_LINE = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     line_valid,
  output logic                     line_ready,
  input  logic [LINE_INSNS*INSN_W-1:0] line_data,
  input  logic [SEQ_W-1:0]         line_stream,
  input  logic [SEQ_W-1:0]         line_pred,
  input  logic [ADDR_W-1:0]        line_pc,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [OUT_W-1:0]         out_lanes,
  output logic [OUT_W*INSN_W-1:0]  out_insn,
  output logic [OUT_W*ADDR_W-1:0]  out_pc,
  output logic [OUT_W*FSEQ_W-1:0]  out_fseq,
  input  logic                     pred_taken,
  input  logic [ADDR_W-1:0]        pred_target,
  output logic                     fetch_redir_valid,
  output logic [ADDR_W-1:0]        fetch_redir_pc,
  output logic [SEQ_W-1:0]         cur_pred,
  input  logic                     ex_redirect,
  input  logic [SEQ_W-1:0]         ex_stream,
  output logic                     drained
);
  localparam int LINE_W = LINE_INSNS * INSN_W;
  localparam int ISZ    = INSN_W / 8;
  localparam int PW     = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int IW     = (LINE_INSNS > 1) ? $clog2(LINE_INSNS) : 1;

  logic [LINE_W-1:0] b_data   [DEPTH];
  logic [SEQ_W-1:0]  b_stream [DEPTH];
  logic [SEQ_W-1:0]  b_pred   [DEPTH];
  logic [ADDR_W-1:0] b_pc     [DEPTH];

  logic [PW-1:0]     wr_q, rd_q;
  logic [PW:0]       cnt_q;
  logic [IW-1:0]     idx_q;
  logic [ADDR_W-1:0] pc_q;
  logic              have_q;
  logic [SEQ_W-1:0]  last_q, exp_q, pred_q;
  logic [FSEQ_W-1:0] fseq_q;

  logic [PW:0]       c_ent;
  logic [IW-1:0]     c_idx;
  logic [ADDR_W-1:0] c_pc;
  logic              c_have;
  logic [SEQ_W-1:0]  c_last;
  logic [FSEQ_W-1:0] c_num;
  logic              stop;
  logic [PW-1:0]     ix;
  logic              head_disc, fire, flush, push;
  logic [PW:0]       pop;

  assign head_disc = (cnt_q != '0) && (b_pred[rd_q] != pred_q) && (b_stream[rd_q] == exp_q);
  assign flush     = ex_redirect | pred_taken;
  assign line_ready = cnt_q < (PW+1)'(DEPTH);
  assign push      = line_valid && line_ready && !flush;
  assign out_valid = (|out_lanes) && !ex_redirect;
  assign fire      = out_valid && out_ready;
  assign pop       = head_disc ? (PW+1)'(1) : (fire ? c_ent : '0);
  assign cur_pred  = pred_q;
  assign fetch_redir_valid = pred_taken && !ex_redirect;
  assign fetch_redir_pc    = pred_target;
  assign drained   = (cnt_q == '0) && (idx_q == '0);

  always_comb begin
    c_ent = '0; c_idx = idx_q; c_pc = pc_q; c_have = have_q; c_last = last_q;
    c_num = '0; stop = 1'b0; ix = rd_q;
    out_lanes = '0; out_insn = '0; out_pc = '0; out_fseq = '0;
    for (int l = 0; l < OUT_W; l++) begin
      ix = rd_q + c_ent[PW-1:0];
      if (!stop && !head_disc && (cnt_q > c_ent) && (c_ent == '0 || MULTI_LINE)) begin
        if (c_ent != '0 && b_pred[ix] != pred_q && b_stream[ix] == exp_q) begin
          stop = 1'b1;
        end else begin
          if (c_idx == '0 && (!c_have || b_stream[ix] != c_last)) begin
            c_pc = b_pc[ix]; c_have = 1'b1; c_last = b_stream[ix];
          end
          out_lanes[l] = 1'b1;
          out_insn[l*INSN_W +: INSN_W] = b_data[ix][int'(c_idx)*INSN_W +: INSN_W];
          out_pc[l*ADDR_W +: ADDR_W]   = c_pc;
          out_fseq[l*FSEQ_W +: FSEQ_W] = fseq_q + FSEQ_W'(l);
          c_num = c_num + 1'b1;
          c_pc  = c_pc + ADDR_W'(ISZ);
          if (int'(c_idx) == LINE_INSNS - 1) begin
            c_idx = '0; c_ent = c_ent + 1'b1;
          end else begin
            c_idx = c_idx + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      b_data[wr_q]   <= line_data;
      b_stream[wr_q] <= line_stream;
      b_pred[wr_q]   <= line_pred;
      b_pc[wr_q]     <= line_pc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0; rd_q <= '0; cnt_q <= '0; idx_q <= '0; pc_q <= '0; have_q <= 1'b0;
      last_q <= '0; exp_q <= '0; pred_q <= '0; fseq_q <= '0;
    end else if (flush) begin
      wr_q <= '0; rd_q <= '0; cnt_q <= '0; idx_q <= '0; have_q <= 1'b0;
      if (ex_redirect) begin
        last_q <= ex_stream;
      end else begin
        pred_q <= pred_q + 1'b1;
        exp_q  <= fire ? c_last : last_q;
        if (fire) begin
          last_q <= c_last;
          fseq_q <= fseq_q + c_num;
        end
      end
    end else begin
      if (push) wr_q <= wr_q + 1'b1;
      rd_q  <= rd_q + pop[PW-1:0];
      cnt_q <= cnt_q + (PW+1)'(push) - pop;
      if (head_disc) begin
        have_q <= 1'b0;
      end else if (fire) begin
        idx_q <= c_idx; pc_q <= c_pc; have_q <= c_have; last_q <= c_last;
        fseq_q <= fseq_q + c_num;
      end
    end
  end
endmodule

module fetch_splitter_chk #(
  parameter int OUT_W  = 3,
  parameter int INSN_W = 32,
  parameter int FSEQ_W = 12,
  parameter int SEQ_W  = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [OUT_W-1:0]        out_lanes,
  input logic [OUT_W*INSN_W-1:0] out_insn,
  input logic [OUT_W*FSEQ_W-1:0] out_fseq,
  input logic                    pred_taken,
  input logic                    ex_redirect,
  input logic                    fetch_redir_valid,
  input logic [SEQ_W-1:0]        cur_pred,
  input logic                    line_ready,
  input logic                    drained
);
  // R2
  lanes_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_lanes & (out_lanes + 1'b1)) == '0));
  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(out_valid && !out_ready && !ex_redirect && !pred_taken) && !ex_redirect)
    |-> (out_valid && $stable(out_insn[INSN_W-1:0]) && $stable(out_fseq[FSEQ_W-1:0])));
  // R6
  fseq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(out_valid && out_ready) && out_valid)
    |-> (out_fseq[FSEQ_W-1:0] == $past(out_fseq[FSEQ_W-1:0]) + FSEQ_W'($past($countones(out_lanes)))));
  // R8
  pred_bump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_taken && !ex_redirect) |=> (cur_pred == $past(cur_pred) + 1'b1));
  // R9
  redir_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ex_redirect |=> (drained && $stable(cur_pred)));
  // R9
  redir_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ex_redirect |-> (!out_valid && !fetch_redir_valid));
  // R10
  room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drained |-> line_ready);
endmodule

bind fetch_splitter fetch_splitter_chk #(.OUT_W(OUT_W), .INSN_W(INSN_W), .FSEQ_W(FSEQ_W), .SEQ_W(SEQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready), .out_lanes(out_lanes),
  .out_insn(out_insn), .out_fseq(out_fseq), .pred_taken(pred_taken), .ex_redirect(ex_redirect),
  .fetch_redir_valid(fetch_redir_valid), .cur_pred(cur_pred), .line_ready(line_ready), .drained(drained));

// File: tb/tb_fetch_splitter.sv
module tb_fetch_splitter;
  localparam int LI = 4, IW = 32, OW = 3, DEPTH = 4, SW = 4, AW = 16, FW = 12;

  logic clk = 0, rst_n = 0;
  logic line_valid = 0, line_ready, out_valid, out_ready = 0;
  logic [LI*IW-1:0] line_data = '0;
  logic [SW-1:0] line_stream = '0, line_pred = '0, ex_stream = '0, cur_pred;
  logic [AW-1:0] line_pc = '0, pred_target = '0, fetch_redir_pc;
  logic [OW-1:0] out_lanes;
  logic [OW*IW-1:0] out_insn;
  logic [OW*AW-1:0] out_pc;
  logic [OW*FW-1:0] out_fseq;
  logic pred_taken = 0, fetch_redir_valid, ex_redirect = 0, drained;

  fetch_splitter dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  logic [IW-1:0] q_insn[$];
  logic [AW-1:0] q_pc[$];
  logic [AW-1:0] m_pc = '0;
  logic [FW-1:0] m_fseq = '0;
  bit rnd_ready = 0;
  bit cur_keep, cur_reload;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic score();
    for (int l = 0; l < OW; l++) begin
      if (out_lanes[l]) begin
        if (q_insn.size() == 0) begin
          chk(0, "R2 R7 unexpected instruction", out_insn[l*IW +: IW], 0);
        end else begin
          chk(out_insn[l*IW +: IW] == q_insn[0] && out_pc[l*AW +: AW] == q_pc[0]
              && out_fseq[l*FW +: FW] == m_fseq, "R2 R5 R6 lane content",
              {out_insn[l*IW +: IW], out_pc[l*AW +: AW]}, {q_insn[0], q_pc[0]});
          void'(q_insn.pop_front()); void'(q_pc.pop_front());
        end
        m_fseq++;
      end
    end
  endtask

  task automatic tick();
    if (rnd_ready) out_ready = ($urandom % 10) < 7;
    #1;
    if (out_valid && out_ready) score();
    if (line_valid && line_ready && !pred_taken && !ex_redirect && cur_keep) begin
      logic [AW-1:0] base;
      base = cur_reload ? line_pc : m_pc;
      for (int i = 0; i < LI; i++) begin
        q_insn.push_back(line_data[i*IW +: IW]);
        q_pc.push_back(base + AW'(4*i));
      end
      m_pc = base + AW'(4*LI);
    end
    @(posedge clk); @(negedge clk);
  endtask

  task automatic push_line(input logic [LI*IW-1:0] d, input logic [SW-1:0] s, input logic [SW-1:0] p,
                           input logic [AW-1:0] pc, input bit keep, input bit reload);
    bit done;
    line_data = d; line_stream = s; line_pred = p; line_pc = pc; line_valid = 1;
    cur_keep = keep; cur_reload = reload;
    done = 0;
    while (!done) begin
      done = line_ready;
      tick();
    end
    line_valid = 0;
  endtask

  task automatic drain_wait();
    for (int i = 0; i < 60 && !(drained && !out_valid); i++) tick();
  endtask

  function automatic logic [LI*IW-1:0] rline();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [LI*IW-1:0] a, b;
    logic [IW-1:0] h_insn;
    logic [FW-1:0] h_fseq;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(!out_valid && drained && cur_pred == 0 && line_ready, "R1 reset state",
        {out_valid, drained, line_ready}, 3'b011);
    @(negedge clk);

    // random phase: one stream, random gaps and stalls
    rnd_ready = 1;
    for (int k = 0; k < 150; k++) begin
      push_line(rline(), 4'd1, 4'd0, (k == 0) ? 16'h0100 : AW'($urandom), 1, k == 0);
      repeat ($urandom % 3) tick();
    end
    rnd_ready = 0; out_ready = 1;
    drain_wait();
    chk(q_insn.size() == 0, "R2 all instructions delivered", q_insn.size(), 0);

    // R3 multi-line fill
    out_ready = 0;
    a = rline(); b = rline();
    push_line(a, 4'd1, 4'd0, 16'hFFFF, 1, 0);
    push_line(b, 4'd1, 4'd0, 16'hFFFF, 1, 0);
    out_ready = 1;
    tick();
    chk(out_lanes == 3'b111 && out_insn[2*IW-1:IW] == b[IW-1:0], "R3 next line fills lanes",
        out_insn[2*IW-1:IW], b[IW-1:0]);
    drain_wait();

    // R4 stall hold and R11 drained while partly held
    out_ready = 0;
    push_line(rline(), 4'd1, 4'd0, 16'h1234, 1, 0);
    #1; h_insn = out_insn[IW-1:0]; h_fseq = out_fseq[FW-1:0];
    repeat (3) tick();
    chk(out_valid && out_insn[IW-1:0] == h_insn && out_fseq[FW-1:0] == h_fseq, "R4 held under stall",
        out_insn[IW-1:0], h_insn);
    chk(!drained, "R11 not drained with line held", drained, 0);
    out_ready = 1;
    tick();
    chk(!drained, "R11 not drained with line partly emitted", drained, 0);
    tick();
    chk(drained && q_insn.size() == 0, "R4 R11 line popped after last", drained, 1);

    // R8 prediction flush
    out_ready = 0;
    push_line(rline(), 4'd1, 4'd0, 16'h0, 0, 0);
    push_line(rline(), 4'd1, 4'd0, 16'h0, 0, 0);
    pred_taken = 1; pred_target = 16'h4000;
    #1;
    chk(fetch_redir_valid && fetch_redir_pc == 16'h4000, "R8 target forwarded", fetch_redir_pc, 16'h4000);
    tick();
    pred_taken = 0;
    chk(cur_pred == 1 && drained && !out_valid, "R8 flush and bump", cur_pred, 1);

    // R7 discard: stale same stream dropped, old pred from new stream kept
    out_ready = 1;
    push_line(rline(), 4'd1, 4'd0, 16'h0, 0, 0);
    repeat (3) tick();
    chk(drained && !out_valid, "R7 stale line dropped", drained, 1);
    push_line(rline(), 4'd2, 4'd0, 16'h0800, 1, 1);
    drain_wait();
    push_line(rline(), 4'd1, 4'd1, 16'h0A00, 1, 1);
    push_line(rline(), 4'd1, 4'd1, 16'h7777, 1, 0);
    drain_wait();
    chk(q_insn.size() == 0, "R5 R7 kept lines delivered", q_insn.size(), 0);

    // R7 discard clears PC: same stream reloads
    pred_taken = 1; tick(); pred_taken = 0;
    push_line(rline(), 4'd1, 4'd1, 16'h0, 0, 0);
    push_line(rline(), 4'd1, 4'd2, 16'h0C00, 1, 1);
    drain_wait();
    chk(q_insn.size() == 0 && cur_pred == 2, "R5 R7 reload after discard", q_insn.size(), 0);

    // R9 redirect
    out_ready = 0;
    push_line(rline(), 4'd1, 4'd2, 16'h0, 0, 0);
    out_ready = 1; ex_redirect = 1; ex_stream = 4'd5;
    #1;
    chk(!out_valid, "R9 output suppressed in redirect cycle", out_valid, 0);
    tick();
    ex_redirect = 0;
    chk(drained, "R9 redirect flushes", drained, 1);
    push_line(rline(), 4'd5, 4'd2, 16'h0E00, 1, 1);
    drain_wait();

    // R9 redirect and prediction together
    out_ready = 0;
    push_line(rline(), 4'd5, 4'd2, 16'h0, 0, 0);
    ex_redirect = 1; pred_taken = 1; ex_stream = 4'd6;
    #1;
    chk(!fetch_redir_valid, "R9 prediction not forwarded under redirect", fetch_redir_valid, 0);
    tick();
    ex_redirect = 0; pred_taken = 0;
    chk(cur_pred == 2 && drained, "R9 redirect wins over prediction", cur_pred, 2);
    out_ready = 1;
    push_line(rline(), 4'd6, 4'd2, 16'h2000, 1, 1);
    drain_wait();

    // R10 offer during flush dropped
    line_valid = 1; line_data = rline(); line_stream = 4'd6; line_pred = 4'd2; cur_keep = 0;
    pred_taken = 1;
    tick();
    pred_taken = 0; line_valid = 0;
    repeat (2) tick();
    chk(drained && !out_valid && cur_pred == 3, "R10 offer in flush cycle dropped", drained, 1);

    // R10 full buffer
    out_ready = 0;
    for (int k = 0; k < DEPTH; k++) push_line(rline(), 4'd6, 4'd3, 16'h3000, 1, k == 0);
    #1;
    chk(!line_ready, "R10 ready low when full", line_ready, 0);
    @(negedge clk);
    out_ready = 1;
    drain_wait();
    chk(q_insn.size() == 0 && drained, "R2 R10 full buffer delivered", q_insn.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule